// File: doc/BRIEF.md
# Byte-Serial Memory Operand Address Generator

This block sits behind an opcode decoder and takes the addressing bytes of one instruction, one byte per cycle in which `byte_vld` is high. The first byte carries a two-bit mode, a three-bit register field and a three-bit operand selector. From that byte alone the block decides whether a scale/index/base byte follows and whether zero, one or four displacement bytes follow. It then absorbs exactly that many further bytes and returns to waiting for the next first byte.

When the last byte of an operand specifier has been taken, the block forms the linear address as the sum of the selected segment base, an optional base register, an optional index register multiplied by 1, 2, 4 or 8, and a sign-extended or full-width displacement. All arithmetic wraps modulo 2^AW. The eight general registers and the segment base are inputs that the surrounding pipeline holds steady while an operand is parsed. When the specifier names a register operand, no address is formed and a flag says so.

The result, the register field and the register-operand flag are registered. They are presented with a one-cycle `done` pulse and then held until the next operand completes.

Top module: `ea_byte_parser`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `reg_oper`, `reg_fld` and `lin_addr` are all zero, and the parser waits for a first byte.
- R2: A first byte is split as mode = bits 7:6, register field = bits 5:3, selector = bits 2:0. `reg_fld` presents the register field of the completed operand.
- R3: Mode 3 completes on the first byte. It raises `reg_oper` and sets `lin_addr` to zero, and no further bytes belong to that operand.
- R4: Mode 0 with selector neither 4 nor 5 completes on the first byte, with address = segment base + register[selector].
- R5: Mode 1 takes one further displacement byte, which is sign-extended and added to the base register.
- R6: Mode 2 takes four further displacement bytes, least significant first, which are added to the base register.
- R7: Mode 0 with selector 5 uses no base register. Four displacement bytes follow, and address = segment base + displacement.
- R8: Selector 4 with mode 0, 1 or 2 inserts a second byte before any displacement. That byte is split as scale = bits 7:6, index = bits 5:3 and base = bits 2:0. The index register is multiplied by 2^scale and added together with the base register.
- R9: An index code of 4 in the second byte adds no index term.
- R10: Mode 0 with a second-byte base code of 5 uses no base register and takes four displacement bytes.
- R11: A cycle with `byte_vld` low consumes nothing. `byte_in` is ignored, and `done` stays low while the outputs hold.
- R12: `done` is high for exactly the one cycle after the edge that absorbs an operand's final byte. It stays low after every other byte, and the results hold until the next completion.
- R13: The address sum wraps modulo 2^AW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| byte_vld | input | 1 | `byte_in` carries an addressing byte this cycle |
| byte_in | input | 8 | Addressing byte |
| gpr_flat | input | 8*AW | Eight general registers, register n at bits n*AW +: AW |
| seg_base | input | AW | Base of the selected segment |
| lin_addr | output | AW | Computed linear address (zero for a register operand) |
| reg_fld | output | 3 | Register field of the completed operand |
| reg_oper | output | 1 | Completed operand names a register, not memory |
| done | output | 1 | One-cycle strobe: outputs hold a new result |

## Verification
Every result is registered once, so `done` and the new `lin_addr`, `reg_fld` and `reg_oper` appear one cycle after the clock edge that absorbs an operand's last byte. That last byte is the first byte itself for mode 3 and for some mode 0 forms, and otherwise the second or a displacement byte. The bench drives each byte on a falling edge and samples on the next falling edge. It therefore checks the completed result exactly one cycle after the last byte, and checks that `done` is low after each earlier byte and after each idle cycle. One further idle cycle after every completion confirms that the strobe has dropped and that the address is held.

// File: rtl/eagen_pkg.sv
package eagen_pkg;

    localparam int unsigned NUM_GPR = 8;
    localparam int unsigned SEL_W   = $clog2(NUM_GPR);

    localparam logic [1:0] MOD_NODISP = 2'd0;
    localparam logic [1:0] MOD_DISP8  = 2'd1;
    localparam logic [1:0] MOD_DISP32 = 2'd2;
    localparam logic [1:0] MOD_REG    = 2'd3;

    localparam logic [SEL_W-1:0] SEL_ESCAPE = 3'd4;
    localparam logic [SEL_W-1:0] SEL_ABSOLUTE = 3'd5;
    localparam logic [SEL_W-1:0] IDX_NONE = 3'd4;

    typedef enum logic [1:0] {
        PH_FIRST,
        PH_SIB,
        PH_DISP
    } phase_e;

    typedef enum logic [1:0] {
        DK_NONE,
        DK_BYTE,
        DK_WORD
    } disp_kind_e;

    typedef struct packed {
        logic             base_en;
        logic [SEL_W-1:0] base_sel;
        logic             idx_en;
        logic [SEL_W-1:0] idx_sel;
        logic [1:0]       scale;
    } addr_terms_t;

    function automatic disp_kind_e disp_kind(input logic [1:0] mode, input logic no_base);
        disp_kind_e k;
        if (no_base)                  k = DK_WORD;
        else if (mode == MOD_DISP8)   k = DK_BYTE;
        else if (mode == MOD_DISP32)  k = DK_WORD;
        else                          k = DK_NONE;
        return k;
    endfunction

endpackage

// File: rtl/eagen_seq.sv
module eagen_seq
    import eagen_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    output logic             fin_o,
    output logic             at_first_o,
    output addr_terms_t      terms_o,
    output logic [AW-1:0]    disp_o,
    output logic             reg_op_o,
    output logic [SEL_W-1:0] reg_f_o
);

    localparam int unsigned DBYTES = AW / 8;
    localparam int unsigned LW     = $clog2(DBYTES + 1);
    localparam int unsigned ACC_W  = AW - 8;

    phase_e           phase_q, phase_n;
    logic [1:0]       mod_q, mod_n;
    logic [SEL_W-1:0] reg_q, reg_n;
    addr_terms_t      t_q, t_n;
    logic             wide_q, wide_n;
    logic [LW-1:0]    left_q, left_n;
    logic [ACC_W-1:0] acc_q, acc_n;
    disp_kind_e       kind;
    logic             fin_c;

    always_comb begin
        phase_n = phase_q;
        mod_n   = mod_q;
        reg_n   = reg_q;
        t_n     = t_q;
        wide_n  = wide_q;
        left_n  = left_q;
        acc_n   = acc_q;
        kind    = DK_NONE;
        fin_c   = 1'b0;
        disp_o  = '0;

        case (phase_q)
            PH_FIRST: begin
                mod_n      = byte_in[7:6];
                reg_n      = byte_in[5:3];
                t_n.base_sel = byte_in[2:0];
                t_n.base_en  = !(byte_in[7:6] == MOD_NODISP && byte_in[2:0] == SEL_ABSOLUTE);
                t_n.idx_en   = 1'b0;
                t_n.idx_sel  = '0;
                t_n.scale    = 2'd0;
                kind = disp_kind(byte_in[7:6], !t_n.base_en);
                if (byte_in[7:6] == MOD_REG) begin
                    fin_c = 1'b1;
                end else if (byte_in[2:0] == SEL_ESCAPE) begin
                    t_n.base_en = 1'b1;
                    phase_n = PH_SIB;
                end else if (kind == DK_NONE) begin
                    fin_c = 1'b1;
                end else begin
                    phase_n = PH_DISP;
                    wide_n  = (kind == DK_WORD);
                    left_n  = (kind == DK_WORD) ? LW'(DBYTES) : LW'(1);
                end
            end
            PH_SIB: begin
                t_n.scale    = byte_in[7:6];
                t_n.idx_sel  = byte_in[5:3];
                t_n.idx_en   = (byte_in[5:3] != IDX_NONE);
                t_n.base_sel = byte_in[2:0];
                t_n.base_en  = !(mod_q == MOD_NODISP && byte_in[2:0] == SEL_ABSOLUTE);
                kind = disp_kind(mod_q, !t_n.base_en);
                if (kind == DK_NONE) begin
                    fin_c = 1'b1;
                end else begin
                    phase_n = PH_DISP;
                    wide_n  = (kind == DK_WORD);
                    left_n  = (kind == DK_WORD) ? LW'(DBYTES) : LW'(1);
                end
            end
            default: begin
                acc_n  = {byte_in, acc_q[ACC_W-1:8]};
                left_n = left_q - LW'(1);
                if (left_q == LW'(1)) fin_c = 1'b1;
                disp_o = wide_q ? {byte_in, acc_q} : {{(AW-8){byte_in[7]}}, byte_in};
            end
        endcase

        if (fin_c) phase_n = PH_FIRST;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= PH_FIRST;
            mod_q   <= '0;
            reg_q   <= '0;
            t_q     <= '0;
            wide_q  <= 1'b0;
            left_q  <= '0;
            acc_q   <= '0;
        end else if (byte_vld) begin
            phase_q <= phase_n;
            mod_q   <= mod_n;
            reg_q   <= reg_n;
            t_q     <= t_n;
            wide_q  <= wide_n;
            left_q  <= left_n;
            acc_q   <= acc_n;
        end
    end

    assign fin_o      = fin_c && byte_vld;
    assign at_first_o = (phase_q == PH_FIRST);
    assign terms_o    = t_n;
    assign reg_op_o   = (phase_q == PH_FIRST) && (byte_in[7:6] == MOD_REG);
    assign reg_f_o    = reg_n;

endmodule

// File: rtl/eagen_sum.sv
module eagen_sum
    import eagen_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic [NUM_GPR*AW-1:0] gpr_flat,
    input  logic [AW-1:0]         seg_base,
    input  addr_terms_t           terms,
    input  logic [AW-1:0]         disp,
    output logic [AW-1:0]         addr
);

    logic [AW-1:0] gpr [NUM_GPR];

    for (genvar g = 0; g < NUM_GPR; g++) begin : g_unpack
        assign gpr[g] = gpr_flat[g*AW +: AW];
    end

    logic [AW-1:0] base_term, idx_term;

    always_comb begin
        base_term = terms.base_en ? gpr[terms.base_sel] : '0;
        idx_term  = terms.idx_en  ? (gpr[terms.idx_sel] << terms.scale) : '0;
        addr      = seg_base + base_term + idx_term + disp;
    end

endmodule

// File: rtl/ea_byte_parser.sv
module ea_byte_parser
    import eagen_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  byte_vld,
    input  logic [7:0]            byte_in,
    input  logic [NUM_GPR*AW-1:0] gpr_flat,
    input  logic [AW-1:0]         seg_base,
    output logic [AW-1:0]         lin_addr,
    output logic [SEL_W-1:0]      reg_fld,
    output logic                  reg_oper,
    output logic                  done
);

    logic             fin;
    logic             at_first;
    addr_terms_t      terms;
    logic [AW-1:0]    disp;
    logic             reg_op;
    logic [SEL_W-1:0] reg_f;
    logic [AW-1:0]    sum;

    eagen_seq #(.AW(AW)) seq_i (
        .clk        (clk),
        .rst        (rst),
        .byte_vld   (byte_vld),
        .byte_in    (byte_in),
        .fin_o      (fin),
        .at_first_o (at_first),
        .terms_o    (terms),
        .disp_o     (disp),
        .reg_op_o   (reg_op),
        .reg_f_o    (reg_f)
    );

    eagen_sum #(.AW(AW)) sum_i (
        .gpr_flat (gpr_flat),
        .seg_base (seg_base),
        .terms    (terms),
        .disp     (disp),
        .addr     (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            lin_addr <= '0;
            reg_fld  <= '0;
            reg_oper <= 1'b0;
            done     <= 1'b0;
        end else begin
            done <= fin;
            if (fin) begin
                lin_addr <= reg_op ? '0 : sum;
                reg_fld  <= reg_f;
                reg_oper <= reg_op;
            end
        end
    end

endmodule

// File: rtl/eagen_chk.sv
module eagen_chk
    import eagen_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  byte_vld,
    input logic [7:0]            byte_in,
    input logic [NUM_GPR*AW-1:0] gpr_flat,
    input logic [AW-1:0]         seg_base,
    input logic [AW-1:0]         lin_addr,
    input logic [SEL_W-1:0]      reg_fld,
    input logic                  reg_oper,
    input logic                  done,
    input logic                  at_first
);

    logic [AW-1:0] plain_addr;
    assign plain_addr = seg_base + gpr_flat[byte_in[2:0]*AW +: AW];

    assert_done_after_byte_R12: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(byte_vld));

    assert_hold_when_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !done |-> ($stable(lin_addr) && $stable(reg_fld) && $stable(reg_oper)));

    assert_reg_operand_R3: assert property (@(posedge clk) disable iff (rst)
        (at_first && byte_vld && byte_in[7:6] == 2'b11)
        |=> (done && reg_oper && lin_addr == '0 && reg_fld == $past(byte_in[5:3])));

    assert_reg_operand_no_addr_R3: assert property (@(posedge clk) disable iff (rst)
        reg_oper |-> (lin_addr == '0));

    assert_plain_base_R4: assert property (@(posedge clk) disable iff (rst)
        (at_first && byte_vld && byte_in[7:6] == 2'b00 && byte_in[2:0] != 3'd4 && byte_in[2:0] != 3'd5)
        |=> (done && !reg_oper && lin_addr == $past(plain_addr)));

    assert_sib_follows_R8: assert property (@(posedge clk) disable iff (rst)
        (at_first && byte_vld && byte_in[7:6] != 2'b11 && byte_in[2:0] == 3'd4)
        |=> !done);

endmodule

bind ea_byte_parser eagen_chk #(.AW(AW)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .byte_vld (byte_vld),
    .byte_in  (byte_in),
    .gpr_flat (gpr_flat),
    .seg_base (seg_base),
    .lin_addr (lin_addr),
    .reg_fld  (reg_fld),
    .reg_oper (reg_oper),
    .done     (done),
    .at_first (at_first)
);

// File: tb/ea_byte_parser_tb.sv
module ea_byte_parser_tb_top;

    localparam int AW = 32;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            byte_vld = 1'b0;
    logic [7:0]      byte_in = '0;
    logic [8*AW-1:0] gpr_flat;
    logic [AW-1:0]   seg_base = '0;
    logic [AW-1:0]   lin_addr;
    logic [2:0]      reg_fld;
    logic            reg_oper;
    logic            done;

    logic [AW-1:0] rf [8];
    logic [31:0]   rng = 32'h1234_5679;
    int            n_chk = 0;
    int            n_bad = 0;
    bit            finished = 0;

    always #5 clk = ~clk;

    always_comb
        for (int i = 0; i < 8; i++) gpr_flat[i*AW +: AW] = rf[i];

    ea_byte_parser #(.AW(AW)) dut_i (
        .clk (clk), .rst (rst), .byte_vld (byte_vld), .byte_in (byte_in),
        .gpr_flat (gpr_flat), .seg_base (seg_base), .lin_addr (lin_addr),
        .reg_fld (reg_fld), .reg_oper (reg_oper), .done (done)
    );

    function automatic logic [31:0] step(input logic [31:0] s);
        logic [31:0] x = s;
        x ^= x << 13;
        x ^= x >> 17;
        x ^= x << 5;
        return x;
    endfunction

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic new_regs();
        for (int i = 0; i < 8; i++) begin
            rng = step(rng);
            rf[i] = rng;
        end
        rng = step(rng);
        seg_base = rng;
    endtask

    task automatic send(input logic [7:0] mb, input logic [7:0] sb,
                        input logic [31:0] dv, input bit gap);
        logic [1:0]    md = mb[7:6];
        logic [2:0]    rm = mb[2:0];
        logic [7:0]    bytes [6];
        int            n = 1;
        bit            sib = (md != 2'd3) && (rm == 3'd4);
        bit            nob;
        logic [AW-1:0] ex_addr;
        logic [AW-1:0] bterm = '0;
        logic [AW-1:0] iterm = '0;
        logic [AW-1:0] dterm = '0;
        int            ndisp = 0;
        string         tag;
        logic [AW-1:0] prev;

        bytes[0] = mb;
        if (md == 2'd3) begin
            ex_addr = '0;
            tag = "R3";
        end else begin
            if (sib) begin
                bytes[n] = sb;
                n++;
                nob = (md == 2'd0) && (sb[2:0] == 3'd5);
                if (!nob) bterm = rf[sb[2:0]];
                if (sb[5:3] != 3'd4) iterm = rf[sb[5:3]] * (32'd1 << sb[7:6]);
                tag = nob ? "R10" : (sb[5:3] == 3'd4) ? "R9" : "R8";
            end else begin
                nob = (md == 2'd0) && (rm == 3'd5);
                if (!nob) bterm = rf[rm];
                tag = nob ? "R7" : (md == 2'd1) ? "R5" : (md == 2'd2) ? "R6" : "R4";
            end
            if (md == 2'd1) begin
                ndisp = 1;
                dterm = {{24{dv[7]}}, dv[7:0]};
            end else if (md == 2'd2 || nob) begin
                ndisp = 4;
                dterm = dv;
            end
            ex_addr = seg_base + bterm + iterm + dterm;
        end
        for (int k = 0; k < ndisp; k++) begin
            bytes[n] = dv[k*8 +: 8];
            n++;
        end

        prev = lin_addr;
        for (int k = 0; k < n; k++) begin
            byte_vld = 1'b1;
            byte_in  = bytes[k];
            @(negedge clk);
            byte_vld = 1'b0;
            byte_in  = ~bytes[k];
            if (k < n - 1) begin
                chk(done == 1'b0, "R12", "strobe before final byte", {31'd0, done}, 32'd0);
                if (gap) begin
                    @(negedge clk);
                    chk(done == 1'b0 && lin_addr == prev, "R11", "idle cycle changed outputs",
                        lin_addr, prev);
                end
            end
        end
        chk(done == 1'b1, tag, "strobe after final byte", {31'd0, done}, 32'd1);
        chk(lin_addr == ex_addr, tag, $sformatf("address mb=%h sb=%h", mb, sb), lin_addr, ex_addr);
        chk(reg_oper == (md == 2'd3), tag, "register operand flag", {31'd0, reg_oper},
            {31'd0, (md == 2'd3)});
        chk(reg_fld == mb[5:3], "R2", "register field", {29'd0, reg_fld}, {29'd0, mb[5:3]});
        @(negedge clk);
        chk(done == 1'b0 && lin_addr == ex_addr, "R12", "strobe length or hold", lin_addr, ex_addr);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        new_regs();
        repeat (3) @(negedge clk);
        chk(done == 0 && reg_oper == 0 && reg_fld == 0 && lin_addr == 0, "R1", "reset state",
            lin_addr, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk(done == 0 && reg_oper == 0 && lin_addr == 0, "R1", "after reset", lin_addr, 32'd0);

        for (int m = 0; m < 256; m++) begin
            if (m % 16 == 0) new_regs();
            rng = step(rng);
            send(8'(m), rng[15:8], step(rng), (m % 5) == 0);
        end

        for (int md = 0; md < 3; md++) begin
            for (int s = 0; s < 256; s++) begin
                if (s % 32 == 0) new_regs();
                rng = step(rng);
                send({2'(md), rng[2:0], 3'd4}, 8'(s), step(rng), (s % 7) == 0);
            end
        end

        seg_base = 32'hFFFF_FF00;
        rf[0] = 32'h0000_0200;
        send(8'h00, 8'h00, 32'd0, 1'b0);
        chk(lin_addr == 32'h0000_0100, "R13", "wrapped sum", lin_addr, 32'h0000_0100);

        seg_base = 32'h0000_0010;
        rf[2] = 32'h0000_0008;
        send(8'h4A, 8'h00, 32'h0000_00F0, 1'b1);
        chk(lin_addr == 32'h0000_0008, "R5", "negative byte displacement", lin_addr, 32'h0000_0008);

        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule